// File: doc/BRIEF.md
# Four-Operation 4-bit Processor Core

This block is a small single-cycle processor core. On every clock edge it reads one 12-bit instruction from an on-chip program store, decodes it, and executes it against eight 4-bit registers. It has four operations: load an immediate into a register, add two registers, negate a register in two's complement, and a conditional jump taken when a register holds zero. Register 0 always reads as zero, so a conditional jump on register 0 is always taken.

The program store holds eight words. Its contents come from a parameter array, so each instance can run its own program without any change to the RTL. The program counter, the register contents and two status flags (signed overflow and zero from the most recent arithmetic) are brought out as ports. A surrounding design or a testbench can observe the full architectural state through these ports after every instruction.

Instruction encoding, MSB first: bits [11:10] hold the opcode, bits [9:7] the first register field, bits [6:4] the second register field, bits [3:0] the immediate, and bits [2:0] the jump target.

Top module: `nano_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC, all eight registers and both flags become zero on that edge.
- R2: Opcode 2'b10 writes the 4-bit immediate in bits [3:0] into the register named by bits [9:7].
- R3: Opcode 2'b00 writes (A + B) mod 16 into register A. A is named by bits [9:7] and B by bits [6:4].
- R4: Opcode 2'b01 replaces the register named by bits [9:7] with (16 − value) mod 16.
- R5: Opcode 2'b11 loads bits [2:0] into the PC when the register named by bits [9:7] is zero. Otherwise the PC advances by one.
- R6: Register 0 reads as zero and ignores every write. A jump on register 0 is therefore always taken.
- R7: Every instruction other than a taken jump advances the PC by exactly one, and the PC wraps from 7 to 0.
- R8: After an add or negate, the overflow flag is set when the result, read as signed 4-bit, differs from the true signed result. The zero flag is set when the 4-bit result is zero.
- R9: Load-immediate and jump instructions leave both flags unchanged.
- R10: The instruction at address k is element k of the `PROG` parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| regs_o | output | 32 | Register contents; register k sits in bits [4k+3:4k] |
| pc_o | output | 3 | Program counter (address of the next instruction) |
| ovf_o | output | 1 | Signed overflow of the most recent add or negate |
| zero_o | output | 1 | Zero result of the most recent add or negate |

## Verification
The embedded properties assume that `rst` is held high across at least one rising edge before normal operation starts. They also assume that the program store holds only well-formed words. The core has no data inputs, so these are its only assumptions. The bench keeps within them by starting every run with a multi-cycle reset and by loading a program whose padding bits are all zero. That program walks an accumulator through all sixteen values and negates a changing register, including the value 8. It includes a discarded write to register 0, both outcomes of the conditional jump, and the PC wrap. A reference interpreter, written from the requirements, predicts every cycle.

// File: rtl/nano_pkg.sv
package nano_pkg;
    localparam int DW     = 4;
    localparam int AW     = 3;
    localparam int NREG   = 8;
    localparam int RW     = $clog2(NREG);
    localparam int IW     = 12;
    localparam int NWORDS = 1 << AW;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_NEG = 2'b01,
        OP_LDI = 2'b10,
        OP_JZ  = 2'b11
    } op_e;

    typedef struct packed {
        op_e           op;
        logic [RW-1:0] ra;
        logic [RW-1:0] rb;
        logic [DW-1:0] imm;
        logic [AW-1:0] tgt;
    } dec_t;

    typedef struct packed {
        logic [AW-1:0] pc;
        logic          ovf;
        logic          zero;
    } core_t;
endpackage

// File: rtl/nano_decode.sv
module nano_decode
    import nano_pkg::*;
(
    input  logic [IW-1:0] instr,
    output dec_t          dec
);
    always_comb begin
        dec.op  = op_e'(instr[IW-1 -: 2]);
        dec.ra  = instr[IW-3 -: RW];
        dec.rb  = instr[IW-3-RW -: RW];
        dec.imm = instr[DW-1:0];
        dec.tgt = instr[AW-1:0];
    end
endmodule

// File: rtl/nano_alu.sv
module nano_alu
    import nano_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          sub,
    output logic [DW-1:0] sum,
    output logic          ovf
);
    logic [DW:0]   carry;
    logic [DW-1:0] bx;

    assign bx       = b ^ {DW{sub}};
    assign carry[0] = sub;

    for (genvar i = 0; i < DW; i++) begin : g_fa
        assign sum[i]     = a[i] ^ bx[i] ^ carry[i];
        assign carry[i+1] = (a[i] & bx[i]) | (carry[i] & (a[i] ^ bx[i]));
    end

    assign ovf = carry[DW] ^ carry[DW-1];
endmodule

// File: rtl/nano_regfile.sv
module nano_regfile
    import nano_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [RW-1:0]        waddr,
    input  logic [DW-1:0]        wdata,
    input  logic [RW-1:0]        raddr_a,
    input  logic [RW-1:0]        raddr_b,
    output logic [DW-1:0]        rdata_a,
    output logic [DW-1:0]        rdata_b,
    output logic [NREG*DW-1:0]   regs_flat
);
    logic [NREG-1:0][DW-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we && waddr != '0) regs_d[waddr] = wdata;
        if (rst) regs_d = '0;
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign rdata_a   = (raddr_a == '0) ? '0 : regs_q[raddr_a];
    assign rdata_b   = (raddr_b == '0) ? '0 : regs_q[raddr_b];
    assign regs_flat = regs_q;

    // R6: a write aimed at register 0 leaves it at zero
    assert_r0_discard_R6: assert property (@(posedge clk) disable iff (rst)
        (we && waddr == '0) |=> regs_q[0] == '0);
endmodule

// File: rtl/nano_core.sv
module nano_core
    import nano_pkg::*;
#(
    parameter logic [NWORDS-1:0][IW-1:0] PROG = {
        12'hC03, 12'hC86, 12'h0A0, 12'h500,
        12'h190, 12'h980, 12'h901, 12'h883
    }
)
(
    input  logic                 clk,
    input  logic                 rst,
    output logic [NREG*DW-1:0]   regs_o,
    output logic [AW-1:0]        pc_o,
    output logic                 ovf_o,
    output logic                 zero_o
);
    core_t         st_d, st_q;
    logic [IW-1:0] instr;
    dec_t          dec;
    logic [DW-1:0] rd_a, rd_b, alu_a, alu_b, alu_sum, wdata;
    logic          alu_ovf, is_alu, we;

    assign instr = PROG[st_q.pc];

    nano_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    assign is_alu = (dec.op == OP_ADD) || (dec.op == OP_NEG);
    assign alu_a  = (dec.op == OP_NEG) ? '0 : rd_a;
    assign alu_b  = (dec.op == OP_NEG) ? rd_a : rd_b;

    nano_alu u_alu (
        .a   (alu_a),
        .b   (alu_b),
        .sub (dec.op == OP_NEG),
        .sum (alu_sum),
        .ovf (alu_ovf)
    );

    assign we    = (dec.op != OP_JZ);
    assign wdata = (dec.op == OP_LDI) ? dec.imm : alu_sum;

    nano_regfile u_rf (
        .clk       (clk),
        .rst       (rst),
        .we        (we),
        .waddr     (dec.ra),
        .wdata     (wdata),
        .raddr_a   (dec.ra),
        .raddr_b   (dec.rb),
        .rdata_a   (rd_a),
        .rdata_b   (rd_b),
        .regs_flat (regs_o)
    );

    always_comb begin
        st_d    = st_q;
        st_d.pc = st_q.pc + 1'b1;
        if (dec.op == OP_JZ && rd_a == '0) st_d.pc = dec.tgt;
        if (is_alu) begin
            st_d.ovf  = alu_ovf;
            st_d.zero = (alu_sum == '0);
        end
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pc_o   = st_q.pc;
    assign ovf_o  = st_q.ovf;
    assign zero_o = st_q.zero;

    logic [NREG-1:0][DW-1:0] regs_v;
    assign regs_v = regs_o;

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (pc_o == '0 && !ovf_o && !zero_o && regs_o == '0));

    assert_pc_step_R7: assert property (@(posedge clk) disable iff (rst)
        (dec.op != OP_JZ) |=> pc_o == $past(pc_o) + 1'b1);

    assert_jump_taken_R5: assert property (@(posedge clk) disable iff (rst)
        (dec.op == OP_JZ && regs_v[dec.ra] == '0) |=> pc_o == $past(dec.tgt));

    assert_flags_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (dec.op == OP_LDI || dec.op == OP_JZ) |=> $stable({ovf_o, zero_o}));

    assert_zero_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (is_alu && dec.ra != '0) |=> zero_o == (regs_v[$past(dec.ra)] == '0));

    assert_add_wb_R3: assert property (@(posedge clk) disable iff (rst)
        (dec.op == OP_ADD && dec.ra != '0)
            |=> regs_v[$past(dec.ra)] == DW'($past(rd_a) + $past(rd_b)));

    assert_ldi_wb_R2: assert property (@(posedge clk) disable iff (rst)
        (dec.op == OP_LDI && dec.ra != '0) |=> regs_v[$past(dec.ra)] == $past(dec.imm));
endmodule

// File: tb/nano_core_test.sv
module nano_core_test;
    import nano_pkg::*;

    localparam logic [NWORDS-1:0][IW-1:0] TPROG = {
        12'h350, 12'hD81, 12'h809, 12'h600,
        12'h2C0, 12'h230, 12'h1A0, 12'h905
    };

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [NREG*DW-1:0]  regs_o;
    logic [AW-1:0]       pc_o;
    logic                ovf_o, zero_o;

    always #2 clk = ~clk;

    nano_core #(.PROG(TPROG)) uut (
        .clk(clk), .rst(rst), .regs_o(regs_o),
        .pc_o(pc_o), .ovf_o(ovf_o), .zero_o(zero_o)
    );

    int n_vec  = 0;
    int n_fail = 0;
    int n_taken = 0, n_wrap = 0, n_ovf = 0, n_neg8 = 0;

    logic [3:0] m_r [8];
    logic [2:0] m_pc;
    logic       m_ovf, m_zero;
    string      m_tag, m_ftag;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int sx(input logic [3:0] v);
        return v[3] ? int'(v) - 16 : int'(v);
    endfunction

    task automatic model_reset();
        foreach (m_r[i]) m_r[i] = '0;
        m_pc = '0; m_ovf = 1'b0; m_zero = 1'b0;
        m_tag = "R1"; m_ftag = "R1";
    endtask

    task automatic model_step();
        logic [11:0] w;
        logic [2:0]  ra, rb;
        logic [3:0]  res;
        int          s;
        w  = TPROG[m_pc];
        ra = w[9:7];
        rb = w[6:4];
        case (w[11:10])
            2'b10: begin
                if (ra != 0) m_r[ra] = w[3:0];
                m_pc = m_pc + 3'd1; m_tag = "R2"; m_ftag = "R9";
            end
            2'b00: begin
                s   = sx(m_r[ra]) + sx(m_r[rb]);
                res = 4'((int'(m_r[ra]) + int'(m_r[rb])) % 16);
                m_ovf = (s > 7) || (s < -8); m_zero = (res == 0);
                if (ra != 0) m_r[ra] = res;
                m_pc = m_pc + 3'd1; m_tag = "R3"; m_ftag = "R8";
            end
            2'b01: begin
                s   = -sx(m_r[ra]);
                res = 4'((16 - int'(m_r[ra])) % 16);
                if (m_r[ra] == 4'd8) n_neg8++;
                m_ovf = (s > 7); m_zero = (res == 0);
                if (ra != 0) m_r[ra] = res;
                m_pc = m_pc + 3'd1; m_tag = "R4"; m_ftag = "R8";
            end
            default: begin
                if (m_r[ra] == 0) begin
                    m_pc = w[2:0]; n_taken++;
                end else begin
                    m_pc = m_pc + 3'd1;
                end
                m_tag = "R5"; m_ftag = "R9";
            end
        endcase
        if (m_pc == 0 && w[11:10] != 2'b11) n_wrap++;
        if (m_ovf) n_ovf++;
    endtask

    task automatic compare();
        chk(pc_o == m_pc, {m_tag, " R7 pc"}, pc_o, m_pc);
        chk(ovf_o == m_ovf, {m_ftag, " ovf"}, ovf_o, m_ovf);
        chk(zero_o == m_zero, {m_ftag, " zero"}, zero_o, m_zero);
        chk(regs_o[3:0] == 4'd0, "R6 reg0", regs_o[3:0], 0);
        for (int k = 1; k < NREG; k++)
            chk(regs_o[k*4 +: 4] == m_r[k], $sformatf("%s reg%0d", m_tag, k),
                regs_o[k*4 +: 4], m_r[k]);
    endtask

    task automatic final_report();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 100000);
        n_vec++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        final_report();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        model_reset();
        compare();                                   // R1 reset state
        rst = 1'b0;
        model_step();
        @(posedge clk); @(negedge clk);
        chk(regs_o[11:8] == 4'd5, "R10 first word", regs_o[11:8], 5);
        compare();
        for (int c = 0; c < 3000; c++) begin
            if (c == 1500) begin                     // R1 mid-run reset
                rst = 1'b1;
                @(posedge clk); @(negedge clk);
                model_reset();
                compare();
                rst = 1'b0;
            end
            model_step();
            @(posedge clk); @(negedge clk);
            compare();
        end
        chk(n_taken > 0, "R5 taken jump seen", n_taken, 1);
        chk(n_wrap > 0, "R7 wrap seen", n_wrap, 1);
        chk(n_ovf > 0, "R8 overflow seen", n_ovf, 1);
        chk(n_neg8 > 0, "R4 negate of 8 seen", n_neg8, 1);
        final_report();
    end
endmodule